// File: doc/BRIEF.md
# Edge Boundary Mask Generator

This block produces the partial-store byte-enable mask for the elements at either end of a row of pixels or array elements. It takes the address of the first byte in the row and the address of the last byte. It looks at where each address falls inside its aligned 8-byte block. For the block that holds the start address, it enables every element from the start to the end of that block. For the block that holds the end address, it enables every element from the beginning of the block up to the end. When both addresses lie in the same 8-byte block, the two masks are combined. Elements can be 8, 16 or 32 bits wide, and they can be ordered big-endian or little-endian inside the block.

The block can also load integer condition flags. It does this by subtracting the end address from the start address, and it produces one set of flags for the 64-bit view and one for the 32-bit view. The flags load only when the caller asks for it; otherwise they keep their last value. By default the mask is registered, so it appears one clock after the inputs. The flags are always held in registers.

Top module: `edge_mask_unit`

## Requirements
- R1: With `elemSize`=0 (8-bit elements) and `littleEnd`=0, the left mask is 0xFF shifted right by start bits 2:0 (s). The right mask has the top (e+1) bits set, where e is end bits 2:0.
- R2: With `elemSize`=0 and `littleEnd`=1, the left mask is 0xFF shifted left by s, kept to 8 bits. The right mask has the low (e+1) bits set.
- R3: With `elemSize`=1 (16-bit elements), the index is address bits 2:1 and the mask is 4 bits wide. Big-endian gives left {F,7,3,1} and right {8,C,E,F}. Little-endian gives left {F,E,C,8} and right {1,3,7,F}.
- R4: With `elemSize`=2 (32-bit elements), the index is address bit 2 and the mask is 2 bits wide. Big-endian gives left {3,1} and right {2,3}. Little-endian gives left {3,2} and right {1,3}.
- R5: If the two addresses agree above bit 2, `maskOut` is left AND right. Otherwise `maskOut` is the left mask alone.
- R6: When `addr32`=1, both addresses are cut to their low 32 bits before the same-block test. Differences above bit 31 then do not separate the blocks.
- R7: When `flagEn`=1, `xccFlags` = {N,Z,V,C} loads from the full 64-bit start−end. The subtraction uses the untruncated addresses even when `addr32`=1. C is the unsigned borrow.
- R8: When `flagEn`=1, `iccFlags` = {N,Z,V,C} loads from the same subtraction taken on bits 31:0 only.
- R9: When `flagEn`=0, both flag outputs keep their values. `flagsValid` equals the `flagEn` of the previous cycle.
- R10: `maskOut` is zero-extended to 8 bits. For 16-bit elements bits 7:4 are 0, and for 32-bit elements bits 7:2 are 0. `elemSize`=3 behaves like 0.
- R11: While `rst_n` is low, `maskOut`, both flag outputs and `flagsValid` are 0. With the default parameters, `maskOut` follows the inputs one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| startAddr | input | 64 | Address of the first byte of the row |
| endAddr | input | 64 | Address of the last byte of the row |
| elemSize | input | 2 | 0: 8-bit, 1: 16-bit, 2: 32-bit, 3: same as 0 |
| littleEnd | input | 1 | 1 selects little-endian element order |
| flagEn | input | 1 | 1 loads the condition flags this cycle |
| addr32 | input | 1 | 1 cuts addresses to 32 bits for the mask |
| maskOut | output | 8 | Zero-extended element mask |
| iccFlags | output | 4 | {N,Z,V,C} of the 32-bit subtraction |
| xccFlags | output | 4 | {N,Z,V,C} of the 64-bit subtraction |
| flagsValid | output | 1 | High when the flags were loaded on the last edge |

## Verification
The mask path is swept over every element size code, both orders, all 64 pairs of low offsets, and three address relations. The relations are: blocks that differ at bit 3, blocks that are equal, and blocks that differ only above bit 31. Each relation is run with `addr32` both off and on. This separates the left-only result from the AND result, and it shows whether the truncation is applied to the block test. The flags are tried on chosen operand pairs: equal values, borrow, signed overflow in each half, and a pair whose low halves match but whose high halves differ, also with `addr32`=1. These pairs separate the 32-bit view from the 64-bit view. Each loaded pair is followed by a cycle with `flagEn`=0 and different operands, which must leave the flags untouched.

// File: rtl/edge_mask_pkg.sv
package edge_mask_pkg;
  localparam int MASK_W = 8;
  localparam int FLAG_W = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } elemSize_e;

  typedef struct packed {
    elemSize_e size;
    logic      little;
    logic      loadFlags;
  } maskCtrl_t;
endpackage

// File: rtl/edge_mask_ctrl.sv
module edge_mask_ctrl
  import edge_mask_pkg::*;
(
  input  logic [1:0] elemSize,
  input  logic       littleEnd,
  input  logic       flagEn,
  output maskCtrl_t  ctrl
);
  always_comb begin
    ctrl.little    = littleEnd;
    ctrl.loadFlags = flagEn;
    case (elemSize)
      2'd1:    ctrl.size = SZ_HALF;
      2'd2:    ctrl.size = SZ_WORD;
      default: ctrl.size = SZ_BYTE;  // code 3 folds onto byte elements
    endcase
  end
endmodule

// File: rtl/edge_mask_dp.sv
module edge_mask_dp
  import edge_mask_pkg::*;
#(
  parameter int ADDR_W       = 64,
  parameter bit REGISTER_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  maskCtrl_t         ctrl,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] endAddr,
  input  logic              addr32,
  output logic [MASK_W-1:0] maskOut,
  output logic [FLAG_W-1:0] iccFlags,
  output logic [FLAG_W-1:0] xccFlags,
  output logic              flagsValid
);
  localparam int LOW_W   = 32;
  localparam int BLK_LSB = 3;
  localparam int HI_W    = ADDR_W - LOW_W;

  // Address conditioning for the mask path only
  logic [ADDR_W-1:0] effStart, effEnd;
  logic              sameBlock;
  assign effStart  = addr32 ? {{HI_W{1'b0}}, startAddr[LOW_W-1:0]} : startAddr;
  assign effEnd    = addr32 ? {{HI_W{1'b0}}, endAddr[LOW_W-1:0]}   : endAddr;
  assign sameBlock = (effStart[ADDR_W-1:BLK_LSB] == effEnd[ADDR_W-1:BLK_LSB]);

  logic [2:0] offL, offR;
  assign offL = effStart[2:0];
  assign offR = effEnd[2:0];

  logic [MASK_W-1:0] leftM, rightM, maskNext;
  logic [3:0]        nibL, nibR;
  logic [1:0]        pairL, pairR;

  always_comb begin
    nibL  = 4'h0;
    nibR  = 4'h0;
    pairL = 2'b00;
    pairR = 2'b00;
    leftM  = '0;
    rightM = '0;
    case (ctrl.size)
      SZ_HALF: begin
        if (ctrl.little) begin
          nibL = 4'hF << offL[2:1];
          nibR = 4'hF >> (2'd3 - offR[2:1]);
        end else begin
          nibL = 4'hF >> offL[2:1];
          nibR = 4'hF << (2'd3 - offR[2:1]);
        end
        leftM  = {4'h0, nibL};
        rightM = {4'h0, nibR};
      end
      SZ_WORD: begin
        if (ctrl.little) begin
          pairL = 2'b11 << offL[2];
          pairR = 2'b11 >> (~offR[2]);
        end else begin
          pairL = 2'b11 >> offL[2];
          pairR = 2'b11 << (~offR[2]);
        end
        leftM  = {6'h00, pairL};
        rightM = {6'h00, pairR};
      end
      default: begin
        if (ctrl.little) begin
          leftM  = 8'hFF << offL;
          rightM = 8'hFF >> (3'd7 - offR);
        end else begin
          leftM  = 8'hFF >> offL;
          rightM = 8'hFF << (3'd7 - offR);
        end
      end
    endcase
    maskNext = sameBlock ? (leftM & rightM) : leftM;
  end

  generate
    if (REGISTER_OUT) begin : g_regMask
      logic [MASK_W-1:0] maskQ;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) maskQ <= '0;
        else        maskQ <= maskNext;
      end
      assign maskOut = maskQ;
    end else begin : g_combMask
      assign maskOut = rst_n ? maskNext : '0;
    end
  endgenerate

  // Flag path: untruncated operands
  logic [ADDR_W-1:0] diff;
  logic [FLAG_W-1:0] xccNext, iccNext;
  assign diff = startAddr - endAddr;

  always_comb begin
    xccNext[3] = diff[ADDR_W-1];
    xccNext[2] = (diff == '0);
    xccNext[1] = (startAddr[ADDR_W-1] ^ endAddr[ADDR_W-1]) &
                 (diff[ADDR_W-1] ^ startAddr[ADDR_W-1]);
    xccNext[0] = (startAddr < endAddr);
    iccNext[3] = diff[LOW_W-1];
    iccNext[2] = (diff[LOW_W-1:0] == '0);
    iccNext[1] = (startAddr[LOW_W-1] ^ endAddr[LOW_W-1]) &
                 (diff[LOW_W-1] ^ startAddr[LOW_W-1]);
    iccNext[0] = (startAddr[LOW_W-1:0] < endAddr[LOW_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iccFlags   <= '0;
      xccFlags   <= '0;
      flagsValid <= 1'b0;
    end else begin
      flagsValid <= ctrl.loadFlags;
      if (ctrl.loadFlags) begin
        iccFlags <= iccNext;
        xccFlags <= xccNext;
      end
    end
  end
endmodule

// File: rtl/edge_mask_unit.sv
module edge_mask_unit
  import edge_mask_pkg::*;
#(
  parameter int ADDR_W       = 64,
  parameter bit REGISTER_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] endAddr,
  input  logic [1:0]        elemSize,
  input  logic              littleEnd,
  input  logic              flagEn,
  input  logic              addr32,
  output logic [7:0]        maskOut,
  output logic [3:0]        iccFlags,
  output logic [3:0]        xccFlags,
  output logic              flagsValid
);
  maskCtrl_t ctrl;

  edge_mask_ctrl u_ctrl (
    .elemSize (elemSize),
    .littleEnd(littleEnd),
    .flagEn   (flagEn),
    .ctrl     (ctrl)
  );

  edge_mask_dp #(
    .ADDR_W      (ADDR_W),
    .REGISTER_OUT(REGISTER_OUT)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .startAddr (startAddr),
    .endAddr   (endAddr),
    .addr32    (addr32),
    .maskOut   (maskOut),
    .iccFlags  (iccFlags),
    .xccFlags  (xccFlags),
    .flagsValid(flagsValid)
  );
endmodule

// File: rtl/edge_mask_unit_chk.sv
module edge_mask_unit_chk #(
  parameter bit REGISTER_OUT = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] elemSize,
  input logic       flagEn,
  input logic [7:0] maskOut,
  input logic [3:0] iccFlags,
  input logic [3:0] xccFlags,
  input logic       flagsValid
);
  // R9
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(flagEn)) |-> ($stable(iccFlags) && $stable(xccFlags)));

  // R9
  flags_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (flagsValid == $past(flagEn)));

  // R8
  zero_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flagsValid && xccFlags[2]) |-> iccFlags[2]);

  generate
    if (REGISTER_OUT) begin : g_regChecks
      // R10
      half_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(elemSize) == 2'd1) |-> (maskOut[7:4] == 4'h0));

      // R10
      word_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(elemSize) == 2'd2) |-> (maskOut[7:2] == 6'h00));
    end
  endgenerate
endmodule

bind edge_mask_unit edge_mask_unit_chk #(.REGISTER_OUT(REGISTER_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .elemSize  (elemSize),
  .flagEn    (flagEn),
  .maskOut   (maskOut),
  .iccFlags  (iccFlags),
  .xccFlags  (xccFlags),
  .flagsValid(flagsValid)
);

// File: tb/edge_mask_unit_bench.sv
module edge_mask_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] startAddr = '0;
  logic [63:0] endAddr = '0;
  logic [1:0]  elemSize = '0;
  logic        littleEnd = 1'b0;
  logic        flagEn = 1'b0;
  logic        addr32 = 1'b0;
  logic [7:0]  maskOut;
  logic [3:0]  iccFlags, xccFlags;
  logic        flagsValid;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  edge_mask_unit u_edge_mask_unit (
    .clk(clk), .rst_n(rst_n), .startAddr(startAddr), .endAddr(endAddr),
    .elemSize(elemSize), .littleEnd(littleEnd), .flagEn(flagEn), .addr32(addr32),
    .maskOut(maskOut), .iccFlags(iccFlags), .xccFlags(xccFlags), .flagsValid(flagsValid)
  );

  task automatic checkVal(string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Element-wise model: element e counts from the lowest address in the block
  function automatic logic [7:0] expMask(int sz, bit le, int offS, int offE, bit same);
    int n;
    int bytesPer;
    int iS;
    int iE;
    logic [7:0] m;
    n = (sz == 1) ? 4 : (sz == 2) ? 2 : 8;
    bytesPer = 8 / n;
    iS = offS / bytesPer;
    iE = offE / bytesPer;
    m = 8'h00;
    for (int e = 0; e < n; e++) begin
      if (e >= iS && (!same || e <= iE))
        m[le ? e : (n - 1 - e)] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [3:0] expFlags64(logic [63:0] a, logic [63:0] b);
    logic [64:0] ud;
    logic signed [64:0] sd;
    ud = {1'b0, a} - {1'b0, b};
    sd = $signed({a[63], a}) - $signed({b[63], b});
    return {ud[63], (ud[63:0] == 64'd0), sd[64] ^ sd[63], ud[64]};
  endfunction

  function automatic logic [3:0] expFlags32(logic [63:0] a, logic [63:0] b);
    logic [32:0] ud;
    logic signed [32:0] sd;
    ud = {1'b0, a[31:0]} - {1'b0, b[31:0]};
    sd = $signed({a[31], a[31:0]}) - $signed({b[31], b[31:0]});
    return {ud[31], (ud[31:0] == 32'd0), sd[32] ^ sd[31], ud[32]};
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [63:0] base;
    logic [63:0] pa [8];
    logic [63:0] pb [8];
    logic [3:0]  heldIcc, heldXcc;

    // R11 reset state
    repeat (3) @(posedge clk);
    #1;
    checkVal("R11 reset mask", {56'd0, maskOut}, 64'd0);
    checkVal("R11 reset flags", {55'd0, flagsValid, iccFlags, xccFlags}, 64'd0);
    rst_n = 1'b1;
    step();

    // Mask sweep: R1 R2 R3 R4 R5 R6 R10
    base = 64'h1234_5678_9ABC_DE00;
    for (int a32 = 0; a32 < 2; a32++)
      for (int rel = 0; rel < 3; rel++)
        for (int sz = 0; sz < 4; sz++)
          for (int le = 0; le < 2; le++)
            for (int os = 0; os < 8; os++)
              for (int oe = 0; oe < 8; oe++) begin
                bit same;
                addr32    = a32[0];
                elemSize  = sz[1:0];
                littleEnd = le[0];
                startAddr = base | 64'(os);
                case (rel)
                  0:       endAddr = base | 64'h8 | 64'(oe);
                  1:       endAddr = base | 64'(oe);
                  default: endAddr = (base ^ 64'h0000_0100_0000_0000) | 64'(oe);
                endcase
                same = (rel == 1) || (rel == 2 && a32 == 1);
                step();
                if (rel == 2)
                  checkVal("R6 truncated block test", {56'd0, maskOut},
                           {56'd0, expMask(sz, le[0], os, oe, same)});
                else if (sz == 1 || sz == 2 || sz == 3)
                  checkVal(sz == 1 ? "R3 half masks" : sz == 2 ? "R4 word masks" : "R10 code3 as byte",
                           {56'd0, maskOut}, {56'd0, expMask(sz, le[0], os, oe, same)});
                else
                  checkVal(le ? "R2 byte little R5" : "R1 byte big R5",
                           {56'd0, maskOut}, {56'd0, expMask(sz, le[0], os, oe, same)});
              end

    // Flag pairs: R7 R8 R9
    pa[0] = 64'd5;                    pb[0] = 64'd3;
    pa[1] = 64'd3;                    pb[1] = 64'd5;
    pa[2] = 64'hDEAD_BEEF_0000_1111;  pb[2] = 64'hDEAD_BEEF_0000_1111;
    pa[3] = 64'h8000_0000_0000_0000;  pb[3] = 64'd1;
    pa[4] = 64'h7FFF_FFFF_FFFF_FFFF;  pb[4] = 64'hFFFF_FFFF_FFFF_FFFF;
    pa[5] = 64'h0000_0001_0000_0005;  pb[5] = 64'd5;
    pa[6] = 64'h0000_0000_8000_0000;  pb[6] = 64'd1;
    pa[7] = 64'h0000_0000_7FFF_FFFF;  pb[7] = 64'h0000_0000_FFFF_FFFF;
    for (int k = 0; k < 8; k++) begin
      addr32    = k[0];
      flagEn    = 1'b1;
      startAddr = pa[k];
      endAddr   = pb[k];
      step();
      checkVal("R7 xcc flags", {60'd0, xccFlags}, {60'd0, expFlags64(pa[k], pb[k])});
      checkVal("R8 icc flags", {60'd0, iccFlags}, {60'd0, expFlags32(pa[k], pb[k])});
      checkVal("R9 valid after load", {63'd0, flagsValid}, 64'd1);
      heldIcc = expFlags32(pa[k], pb[k]);
      heldXcc = expFlags64(pa[k], pb[k]);
      flagEn    = 1'b0;
      startAddr = pb[k] ^ 64'h5555_0000_0000_0001;
      endAddr   = pa[k] + 64'd7;
      step();
      checkVal("R9 flags held", {56'd0, iccFlags, xccFlags}, {56'd0, heldIcc, heldXcc});
      checkVal("R9 valid low", {63'd0, flagsValid}, 64'd0);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule